// File: doc/BRIEF.md
# Segmented Data Memory Address Extender

This block sits between the 8-bit data port of a small processor core and a 16-bit data RAM address bus. Each data access carries a one-byte address. The block turns that byte into a 16-bit physical address by means of an 8-bit segment register that is itself mapped into the byte address space.

A byte address with its top bit clear selects an offset inside one of 256 segments of 128 bytes. The segment register supplies the upper byte of the physical address. A byte address with its top bit set always reaches the fixed register area at physical 0x0080–0x00FF, whatever the segment register holds.

The block also holds the stack pointer and carries out push and pop requests. Stack traffic always lands in segment 0 and never alters the segment register. The RAM is external and synchronous. Read data comes back one cycle after the request. The block merges that data with reads of the segment register into one returned read channel.

Top module: `seg_addr_ext`

## Requirements
- R1: While reset is active and on release, the segment register reads 0x00, the stack pointer reads 0x6F, rd_valid is low, and an idle request drives ram_en low.
- R2: A normal access whose byte address has bit 7 set, other than 0xFF, drives ram_addr = {0x00, address}, whatever the segment value.
- R3: A normal access whose byte address has bit 7 clear drives ram_addr = {segment value, address}. Segment n thus covers n*0x100 to n*0x100+0x7F.
- R4: A normal write to byte address 0xFF loads acc_wdata into the segment register at the next clock edge. It does not touch the RAM (ram_en low in that cycle). Accesses from the following cycle on use the new segment.
- R5: A normal read of byte address 0xFF does not touch the RAM (ram_en low). One cycle later it returns the segment value held at the time of the request, with rd_valid high.
- R6: A push writes push_data at ram_addr = {0x00, SP} and then decrements SP by one, wrapping from 0x00 to 0xFF.
- R7: A pop increments SP by one, wrapping from 0xFF to 0x00, and reads ram_addr = {0x00, new SP}. The data is returned one cycle later with rd_valid high.
- R8: Push and pop always use segment 0, whatever the segment value. They never change the segment register, even when SP addresses 0xFF.
- R9: A push or pop requested in the same cycle as a normal access takes priority, and the normal access is dropped. When push and pop are requested together, the push is performed.
- R10: A normal RAM read drives ram_en high with ram_we low. In the following cycle rd_valid is high and rd_data equals ram_rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Normal data access request |
| acc_we | input | 1 | Normal access is a write |
| acc_addr | input | 8 | Byte address of the normal access |
| acc_wdata | input | 8 | Write data of the normal access |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| push_data | input | 8 | Data to push |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM physical address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after a read strobe |
| rd_valid | output | 1 | Returned read data is valid |
| rd_data | output | 8 | Returned read data |
| seg_value | output | 8 | Current segment register |
| sp_value | output | 8 | Current stack pointer |

## Verification
The assertions check on every cycle several rules that hold locally. Upper-half accesses keep a zero high byte and lower-half accesses carry the segment. Stack traffic stays in segment 0 and leaves the segment untouched. Push and pop step the pointer by one, and every read is answered in the next cycle.

Some behaviour shows only in the bench's scenarios against its reference model:
- data landing in, and coming back from, the intended segment after the segment is switched
- last-in-first-out order of the stack
- wrap of the pointer across 0x00/0xFF
- the priority outcome when requests collide

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int OFF_W  = 8;
  localparam int SEG_W  = 8;
  localparam int DATA_W = 8;
  localparam int PHYS_W = SEG_W + OFF_W;

  typedef logic [OFF_W-1:0]  baddr_t;
  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [PHYS_W-1:0] phys_t;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_RAM_RD,
    OP_RAM_WR,
    OP_SEG_RD,
    OP_SEG_WR
  } op_e;

  // Normal access: top bit set stays in the fixed area, otherwise banked.
  function automatic phys_t map_direct(seg_t s, baddr_t a);
    if (a[OFF_W-1]) return {{SEG_W{1'b0}}, a};
    return {s, a};
  endfunction

  // Stack access: always segment 0.
  function automatic phys_t map_stack(baddr_t p);
    return {{SEG_W{1'b0}}, p};
  endfunction

  function automatic baddr_t sp_dec(baddr_t p);
    return p - baddr_t'(1);
  endfunction

  function automatic baddr_t sp_inc(baddr_t p);
    return p + baddr_t'(1);
  endfunction
endpackage

// File: rtl/segx_arbiter.sv
module segx_arbiter
  import segx_pkg::*;
#(
  parameter baddr_t SEG_ADDR = 8'hFF
) (
  input  logic   acc_req,
  input  logic   acc_we,
  input  baddr_t acc_addr,
  input  logic   push_req,
  input  logic   pop_req,
  output op_e    op
);
  always_comb begin
    op = OP_IDLE;
    if (push_req) begin
      op = OP_PUSH;
    end else if (pop_req) begin
      op = OP_POP;
    end else if (acc_req) begin
      if (acc_addr == SEG_ADDR) op = acc_we ? OP_SEG_WR : OP_SEG_RD;
      else                      op = acc_we ? OP_RAM_WR : OP_RAM_RD;
    end
  end
endmodule

// File: rtl/segx_state.sv
module segx_state
  import segx_pkg::*;
#(
  parameter baddr_t RESET_SP = 8'h6F
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   seg_wr,
  input  data_t  seg_wdata,
  input  logic   push_evt,
  input  logic   pop_evt,
  output seg_t   seg_q,
  output baddr_t sp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_q <= '0;
    else if (seg_wr) seg_q <= seg_t'(seg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= RESET_SP;
    else if (push_evt) sp_q <= sp_dec(sp_q);
    else if (pop_evt) sp_q <= sp_inc(sp_q);
  end
endmodule

// File: rtl/segx_addr_map.sv
module segx_addr_map
  import segx_pkg::*;
(
  input  op_e    op,
  input  seg_t   seg,
  input  baddr_t sp,
  input  baddr_t acc_addr,
  input  data_t  acc_wdata,
  input  data_t  push_data,
  output logic   ram_en,
  output logic   ram_we,
  output phys_t  ram_addr,
  output data_t  ram_wdata
);
  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = '0;
    ram_wdata = '0;
    case (op)
      OP_PUSH: begin
        ram_en    = 1'b1;
        ram_we    = 1'b1;
        ram_addr  = map_stack(sp);
        ram_wdata = push_data;
      end
      OP_POP: begin
        ram_en   = 1'b1;
        ram_addr = map_stack(sp_inc(sp));
      end
      OP_RAM_RD: begin
        ram_en   = 1'b1;
        ram_addr = map_direct(seg, acc_addr);
      end
      OP_RAM_WR: begin
        ram_en    = 1'b1;
        ram_we    = 1'b1;
        ram_addr  = map_direct(seg, acc_addr);
        ram_wdata = acc_wdata;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/segx_read_return.sv
module segx_read_return
  import segx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ram_rd_evt,
  input  logic  seg_rd_evt,
  input  seg_t  seg,
  input  data_t ram_rdata,
  output logic  rd_valid,
  output data_t rd_data
);
  logic  pend_q;
  logic  from_seg_q;
  seg_t  snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      from_seg_q <= 1'b0;
      snap_q     <= '0;
    end else begin
      pend_q     <= ram_rd_evt | seg_rd_evt;
      from_seg_q <= seg_rd_evt;
      if (seg_rd_evt) snap_q <= seg;
    end
  end

  assign rd_valid = pend_q;
  assign rd_data  = !pend_q ? '0 : (from_seg_q ? data_t'(snap_q) : ram_rdata);
endmodule

// File: rtl/seg_addr_ext.sv
module seg_addr_ext
  import segx_pkg::*;
#(
  parameter logic [7:0] RESET_SP = 8'h6F,
  parameter logic [7:0] SEG_ADDR = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_req,
  input  logic        acc_we,
  input  logic [7:0]  acc_addr,
  input  logic [7:0]  acc_wdata,
  input  logic        push_req,
  input  logic        pop_req,
  input  logic [7:0]  push_data,
  output logic        ram_en,
  output logic        ram_we,
  output logic [15:0] ram_addr,
  output logic [7:0]  ram_wdata,
  input  logic [7:0]  ram_rdata,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic [7:0]  seg_value,
  output logic [7:0]  sp_value
);
  op_e    op;
  seg_t   seg_q;
  baddr_t sp_q;

  // Named internal events for the checker.
  logic push_evt, pop_evt, seg_wr_evt, seg_rd_evt, ram_rd_evt;

  segx_arbiter #(.SEG_ADDR(SEG_ADDR)) u_arb (
    .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
    .push_req(push_req), .pop_req(pop_req), .op(op)
  );

  assign push_evt   = (op == OP_PUSH);
  assign pop_evt    = (op == OP_POP);
  assign seg_wr_evt = (op == OP_SEG_WR);
  assign seg_rd_evt = (op == OP_SEG_RD);
  assign ram_rd_evt = (op == OP_RAM_RD) || (op == OP_POP);

  segx_state #(.RESET_SP(RESET_SP)) u_state (
    .clk(clk), .rst_n(rst_n),
    .seg_wr(seg_wr_evt), .seg_wdata(acc_wdata),
    .push_evt(push_evt), .pop_evt(pop_evt),
    .seg_q(seg_q), .sp_q(sp_q)
  );

  segx_addr_map u_map (
    .op(op), .seg(seg_q), .sp(sp_q),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .push_data(push_data),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  segx_read_return u_ret (
    .clk(clk), .rst_n(rst_n),
    .ram_rd_evt(ram_rd_evt), .seg_rd_evt(seg_rd_evt),
    .seg(seg_q), .ram_rdata(ram_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign seg_value = seg_q;
  assign sp_value  = sp_q;
endmodule

// File: rtl/segx_checker.sv
module segx_checker #(
  parameter logic [7:0] RESET_SP = 8'h6F,
  parameter logic [7:0] SEG_ADDR = 8'hFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_req,
  input logic [7:0]  acc_addr,
  input logic [7:0]  acc_wdata,
  input logic        push_req,
  input logic        pop_req,
  input logic        ram_en,
  input logic        ram_we,
  input logic [15:0] ram_addr,
  input logic        rd_valid,
  input logic [7:0]  rd_data,
  input logic [7:0]  seg_value,
  input logic [7:0]  sp_value,
  input logic        push_evt,
  input logic        pop_evt,
  input logic        seg_wr_evt,
  input logic        seg_rd_evt
);
  logic direct_ram;
  assign direct_ram = acc_req && !push_req && !pop_req && (acc_addr != SEG_ADDR);

  a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (seg_value == 8'h00 && sp_value == RESET_SP && !rd_valid));

  a_r2_upper_unbanked: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_ram && acc_addr[7]) |-> (ram_en && ram_addr == {8'h00, acc_addr}));

  a_r3_lower_banked: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_ram && !acc_addr[7]) |-> (ram_en && ram_addr == {seg_value, acc_addr}));

  a_r4_seg_load: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_evt |=> (seg_value == $past(acc_wdata)));

  a_r4_seg_write_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr_evt |-> !ram_en);

  a_r5_seg_read_return: assert property (@(posedge clk) disable iff (!rst_n)
    seg_rd_evt |=> (rd_valid && rd_data == $past(seg_value)));

  a_r5_seg_read_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
    seg_rd_evt |-> !ram_en);

  a_r6_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> (sp_value == 8'($past(sp_value) - 8'd1)));

  a_r7_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> (sp_value == 8'($past(sp_value) + 8'd1)));

  a_r8_stack_seg0: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req || pop_req) |-> (ram_en && ram_addr[15:8] == 8'h00));

  a_r8_stack_keeps_seg: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req || pop_req) |=> $stable(seg_value));

  a_r9_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> (push_evt && !pop_evt && ram_we));

  a_r9_stack_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req || pop_req) |-> (!seg_wr_evt && !seg_rd_evt));

  a_r10_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_we) |=> rd_valid);
endmodule

bind seg_addr_ext segx_checker #(.RESET_SP(RESET_SP), .SEG_ADDR(SEG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_addr(acc_addr),
  .acc_wdata(acc_wdata), .push_req(push_req), .pop_req(pop_req),
  .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
  .rd_valid(rd_valid), .rd_data(rd_data),
  .seg_value(seg_value), .sp_value(sp_value),
  .push_evt(push_evt), .pop_evt(pop_evt),
  .seg_wr_evt(seg_wr_evt), .seg_rd_evt(seg_rd_evt)
);

// File: tb/sim_seg_addr_ext.sv
`timescale 1ns/1ps
module sim_seg_addr_ext;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_req = 1'b0, acc_we = 1'b0;
  logic [7:0]  acc_addr = '0, acc_wdata = '0;
  logic        push_req = 1'b0, pop_req = 1'b0;
  logic [7:0]  push_data = '0;
  logic        ram_en, ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data, seg_value, sp_value;

  always #2.5 clk = ~clk;

  seg_addr_ext u0 (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .push_req(push_req),
    .pop_req(pop_req), .push_data(push_data), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .seg_value(seg_value), .sp_value(sp_value)
  );

  // Environment RAM with one cycle of read latency.
  logic [7:0] bram [int];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) bram[int'(ram_addr)] = ram_wdata;
      else ram_rdata <= bram.exists(int'(ram_addr)) ? bram[int'(ram_addr)] : 8'h00;
    end
  end

  // Reference model state.
  int  m_seg = 0;
  int  m_sp  = 'h6F;
  int  m_mem [int];
  bit  exp_rv = 0;
  int  exp_rd = 0;
  string exp_tag = "R10";

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  task automatic chk(string req, bit ok, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mread(int a);
    return m_mem.exists(a) ? m_mem[a] : 0;
  endfunction

  task automatic cyc(bit a_req, bit a_we, int a_addr, int a_wd, bit pu, bit po, int pd);
    bit e_en, e_we; int e_addr, e_wd; string tag;
    bit n_rv; int n_rd; string n_tag;
    acc_req = a_req; acc_we = a_we; acc_addr = 8'(a_addr); acc_wdata = 8'(a_wd);
    push_req = pu; pop_req = po; push_data = 8'(pd);
    #1;
    e_en = 0; e_we = 0; e_addr = 0; e_wd = 0; tag = "R1";
    n_rv = 0; n_rd = 0; n_tag = "R10";
    if (pu) begin
      e_en = 1; e_we = 1; e_addr = m_sp; e_wd = pd; tag = (a_req || po) ? "R9" : "R6";
    end else if (po) begin
      e_en = 1; e_addr = (m_sp + 1) & 255; tag = a_req ? "R9" : "R7";
    end else if (a_req) begin
      if (a_addr == 'hFF) begin
        tag = a_we ? "R4" : "R5";
      end else begin
        e_en = 1; e_we = a_we; e_wd = a_wd;
        if (a_addr >= 'h80) begin e_addr = a_addr; tag = "R2"; end
        else begin e_addr = m_seg * 256 + a_addr; tag = "R3"; end
      end
    end
    chk(tag, ram_en == e_en, ram_en, e_en);
    if (e_en) begin
      chk(tag, ram_we == e_we, ram_we, e_we);
      chk(tag, int'(ram_addr) == e_addr, ram_addr, e_addr);
      if (e_we) chk(tag, int'(ram_wdata) == e_wd, ram_wdata, e_wd);
    end
    chk("R8", int'(seg_value) == m_seg, seg_value, m_seg);
    chk((pu || po) ? "R8" : "R6", int'(sp_value) == m_sp, sp_value, m_sp);
    chk(exp_tag, rd_valid == exp_rv, rd_valid, exp_rv);
    if (exp_rv) chk(exp_tag, int'(rd_data) == exp_rd, rd_data, exp_rd);
    // Next-state of the reference model.
    if (pu) begin
      m_mem[m_sp] = pd; m_sp = (m_sp - 1) & 255;
    end else if (po) begin
      m_sp = (m_sp + 1) & 255; n_rv = 1; n_rd = mread(m_sp); n_tag = "R7";
    end else if (a_req) begin
      if (a_addr == 'hFF) begin
        if (a_we) m_seg = a_wd & 255;
        else begin n_rv = 1; n_rd = m_seg; n_tag = "R5"; end
      end else if (a_we) m_mem[e_addr] = a_wd & 255;
      else begin n_rv = 1; n_rd = mread(e_addr); n_tag = "R10"; end
    end
    exp_rv = n_rv; exp_rd = n_rd; exp_tag = n_tag;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(int a, int d); cyc(1, 1, a, d, 0, 0, 0); endtask
  task automatic rd(int a); cyc(1, 0, a, 0, 0, 0, 0); endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #750000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", seg_value == 8'h00, seg_value, 0);
    chk("R1", sp_value == 8'h6F, sp_value, 'h6F);
    chk("R1", rd_valid == 1'b0, rd_valid, 0);
    chk("R1", ram_en == 1'b0, ram_en, 0);
    rst_n = 1'b1;
    idle();
    // Upper half with segment 0, then segment switch
    wr('h80, 'h11); wr('hA5, 'h22); wr('hFE, 'h33); rd('hA5); rd('h80);
    wr('hFF, 'h3C); rd('hFF); idle();
    rd('hFE); rd('hA5);
    // Lower half banked
    wr('h10, 'h5A); rd('h10); wr('hFF, 'h01); rd('h10); wr('h10, 'hC3);
    wr('hFF, 'h3C); rd('h10); wr('hFF, 'h01); rd('h10);
    // Boundaries 0x7F / 0x80 with segment 0xFF
    wr('hFF, 'hFF); wr('h7F, 'h77); wr('h80, 'h88); wr('h00, 'h01);
    rd('h7F); rd('h80); rd('h00); rd('hFF);
    // Stack LIFO in segment 0
    cyc(0, 0, 0, 0, 1, 0, 'hA1); cyc(0, 0, 0, 0, 1, 0, 'hB2); cyc(0, 0, 0, 0, 1, 0, 'hC3);
    cyc(0, 0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0, 1, 0); idle();
    // Collisions
    cyc(1, 1, 'hFF, 'h42, 1, 0, 'hD4); rd('hFF);
    cyc(1, 0, 'h20, 0, 1, 1, 'hE5); cyc(1, 0, 'hFF, 0, 0, 1, 0); idle();
    cyc(1, 1, 'h30, 'h99, 0, 1, 0); rd('h30);
    // Wrap of the stack pointer
    for (int i = 0; i < 120; i++) cyc(0, 0, 0, 0, 1, 0, i + 7);
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0, 0, 1, 0);
    rd('hFF);
    // Mixed traffic
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0: cyc(0, 0, 0, 0, 1, 0, $urandom_range(0, 255));
        1: cyc(0, 0, 0, 0, 0, 1, 0);
        2: wr('hFF, $urandom_range(0, 3));
        3: rd('hFF);
        4: cyc(1, $urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 255),
               $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 255));
        5: idle();
        6, 7: wr($urandom_range(0, 255), $urandom_range(0, 255));
        default: rd($urandom_range(0, 255));
      endcase
    end
    idle(); idle();
    summary();
  end
endmodule